// File: doc/BRIEF.md
# Dithered Phase-Accumulator Sine Oscillator

This block is a single-channel numerically controlled oscillator. A 32-bit phase accumulator advances by a programmable increment on each enabled clock, so the output frequency is `f_clk * increment / 2^32`. At a 100 MHz clock, an increment of 42,949,673 gives a 1 MHz tone and 429,496,730 gives a 10 MHz tone. The accumulator is reduced to a 12-bit angle. Before that truncation, a small pseudo-random offset is added below the cut point. This spreads the truncation error into broadband noise instead of discrete spurs.

The angle is folded into one quadrant. A 33-entry quarter-wave table gives the sine and cosine of the coarse part of the folded angle. One multiply then refines the result to first order: `sin(c + f) ~ sin(c) + cos(c) * f`. The result is clamped to the 13-bit two's-complement range and negated in the lower half-cycle. The block produces one sample per clock, and a valid flag follows the enable through the pipeline.

Top module: `nco_dither_sine`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the stored increment and every pipeline stage. While reset is held, `sample_o` is 0 and `valid_o` is 0. The first sample after reset is taken at phase 0 and equals 0.
- R2: On every clock with `en` high, the accumulator adds the increment stored on the previous enabled clock, modulo 2^32, and `phase_inc` is stored for the next enabled clock.
- R3: On a clock with `en` low, the accumulator and the stored increment keep their values, `phase_inc` has no effect, and no sample is emitted for that clock.
- R4: Each clock edge that samples `en` high yields exactly one sample, in order. That sample is presented with `valid_o` high after the 5th rising edge, counting the sampling edge as the first.
- R5: A 4-bit value from a free-running LFSR is added at accumulator bits [19:16] before bits [31:20] are taken as the angle. The angle therefore never falls below the truncated accumulator value and exceeds it by at most one step.
- R6: Every emitted sample lies within ±14 of round(4095·sin(2π·acc/2^32)), where acc is the accumulator value after the enabled update that produced it.
- R7: At angles 0 and 2048 the sample is 0. At angle 1024 it is +4095, and at angle 3072 it is −4095.
- R8: The magnitude never exceeds 4095. At angle 1023 the first-order estimate overshoots and is clamped to +4095; at angle 3071 it is clamped to −4095.
- R9: With the increments for 1 MHz and 10 MHz held constant, the sample stream follows the sine of the accumulated phase within the R6 bound across many accumulator wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable; advances phase and stores the increment |
| phase_inc | input | 32 | Phase increment per enabled clock |
| sample_o | output | 13 | Signed sine sample, two's complement |
| valid_o | output | 1 | High when `sample_o` carries a new sample |

## Verification
A wrong accumulator or stored increment shows up as a phase error. The phase error appears in the first sample that uses that accumulator value, five clocks later, and it persists, because every later sample inherits it. The quarter-wave points with all low accumulator bits at zero are immune to the dither, so a folding, sign or table fault there shows as an exact mismatch rather than a tolerance miss. A lost or extra enable shows as a valid pulse with no expected item, or as a latency mismatch on the very next sample. A missing clamp is exposed at angle 1023 or 3071 within the same five-clock window.

// File: rtl/nco_pkg.sv
`timescale 1ns/1ps
package nco_pkg;

    localparam int ACC_W_DEF    = 32;
    localparam int ANG_W_DEF    = 12;
    localparam int OUT_W_DEF    = 13;
    localparam int DITH_W_DEF   = 4;
    localparam int LFSR_W_DEF   = 16;
    localparam int COARSE_W_DEF = 5;
    localparam int CORR_SH_DEF  = 20;
    localparam int PIPE_LAT     = 5;

    // pi/2 in Q30
    localparam longint HALF_PI_Q30 = 64'sd1686629713;
    localparam longint ONE_Q30     = 64'sd1073741824;

    typedef enum logic [1:0] {
        QD_RISE  = 2'd0,
        QD_FALL  = 2'd1,
        QD_DIP   = 2'd2,
        QD_CLIMB = 2'd3
    } quad_e;

    function automatic logic quad_mirrored(quad_e q);
        return (q == QD_FALL) || (q == QD_CLIMB);
    endfunction

    function automatic logic quad_negative(quad_e q);
        return (q == QD_DIP) || (q == QD_CLIMB);
    endfunction

    // amp * sin(k * (pi/2) / 2^coarse_w), built by repeated fixed-point rotation
    function automatic int quarter_sine(int k, int coarse_w, int amp);
        longint th, t2, t3, t4, t5, cs, sn, c, s, nc, ns;
        th = (HALF_PI_Q30 + (64'sd1 <<< (coarse_w - 1))) >>> coarse_w;
        t2 = (th * th) >>> 30;
        t3 = (t2 * th) >>> 30;
        t4 = (t3 * th) >>> 30;
        t5 = (t4 * th) >>> 30;
        cs = ONE_Q30 - t2 / 2 + t4 / 24;
        sn = th - t3 / 6 + t5 / 120;
        c  = ONE_Q30;
        s  = 64'sd0;
        for (int i = 0; i < k; i++) begin
            nc = (c * cs - s * sn) >>> 30;
            ns = (s * cs + c * sn) >>> 30;
            c  = nc;
            s  = ns;
        end
        return int'((s * longint'(amp) + (ONE_Q30 >>> 1)) >>> 30);
    endfunction

    // radians per fine-angle step, scaled by 2^corr_sh
    function automatic int fine_step(int qtr_w, int corr_sh);
        return int'((HALF_PI_Q30 >>> (30 - corr_sh)) >>> qtr_w);
    endfunction

endpackage

// File: rtl/nco_lfsr.sv
`timescale 1ns/1ps
module nco_lfsr #(
    parameter int          LFSR_W = 16,
    parameter int          OUT_W  = 4,
    parameter logic [15:0] TAPS   = 16'hB400,
    parameter logic [15:0] SEED   = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst,
    output logic [OUT_W-1:0] dith_o
);
    logic [LFSR_W-1:0] state_q;
    logic              fb;

    assign fb     = ^(state_q & LFSR_W'(TAPS));
    assign dith_o = state_q[OUT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LFSR_W'(SEED);
        end else begin
            state_q <= {state_q[LFSR_W-2:0], fb};
        end
    end
endmodule

// File: rtl/nco_phase.sv
`timescale 1ns/1ps
module nco_phase #(
    parameter int ACC_W     = nco_pkg::ACC_W_DEF,
    parameter int ANG_W     = nco_pkg::ANG_W_DEF,
    parameter int DITH_W    = nco_pkg::DITH_W_DEF,
    parameter int LFSR_W    = nco_pkg::LFSR_W_DEF,
    parameter bit DITHER_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [ACC_W-1:0] phase_inc,
    output logic [ACC_W-1:0] acc_o,
    output logic [ACC_W-1:0] inc_o,
    output logic [ANG_W-1:0] ang_o,
    output logic             ang_vld_o
);
    localparam int CUT_SH  = ACC_W - ANG_W;
    localparam int DITH_SH = CUT_SH - DITH_W;

    logic [ACC_W-1:0]  acc_q, inc_q;
    logic              acc_vld_q;
    logic [DITH_W-1:0] dith;
    logic [ANG_W-1:0]  ang_d, ang_q;
    logic              ang_vld_q;

    generate
        if (DITHER_EN) begin : g_dith
            nco_lfsr #(.LFSR_W(LFSR_W), .OUT_W(DITH_W)) u_lfsr (
                .clk    (clk),
                .rst    (rst),
                .dith_o (dith)
            );
        end else begin : g_nodith
            assign dith = '0;
        end
    endgenerate

    // stage 1: accumulator, increment stored only on enabled clocks
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            inc_q     <= '0;
            acc_vld_q <= 1'b0;
        end else begin
            acc_vld_q <= en;
            if (en) begin
                acc_q <= acc_q + inc_q;
                inc_q <= phase_inc;
            end
        end
    end

    // stage 2: dither below the cut, then truncate
    assign ang_d = ANG_W'((acc_q + (ACC_W'(dith) << DITH_SH)) >> CUT_SH);

    always_ff @(posedge clk) begin
        if (rst) begin
            ang_q     <= '0;
            ang_vld_q <= 1'b0;
        end else begin
            ang_q     <= ang_d;
            ang_vld_q <= acc_vld_q;
        end
    end

    assign acc_o     = acc_q;
    assign inc_o     = inc_q;
    assign ang_o     = ang_q;
    assign ang_vld_o = ang_vld_q;
endmodule

// File: rtl/nco_sine.sv
`timescale 1ns/1ps
module nco_sine #(
    parameter int ANG_W    = nco_pkg::ANG_W_DEF,
    parameter int OUT_W    = nco_pkg::OUT_W_DEF,
    parameter int COARSE_W = nco_pkg::COARSE_W_DEF,
    parameter int CORR_SH  = nco_pkg::CORR_SH_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ANG_W-1:0]        ang_i,
    input  logic                    vld_i,
    output logic signed [OUT_W-1:0] sample_o,
    output logic                    vld_o
);
    import nco_pkg::*;

    localparam int QTR_W  = ANG_W - 2;
    localparam int FINE_W = QTR_W - COARSE_W;
    localparam int NTAB   = (1 << COARSE_W) + 1;
    localparam int AMP    = (1 << (OUT_W - 1)) - 1;
    localparam int MAG_W  = OUT_W - 1;
    localparam int FK     = fine_step(QTR_W, CORR_SH);
    localparam int FK_W   = FINE_W + $clog2(FK + 1);
    localparam int PROD_W = MAG_W + FK_W;
    localparam int CIX_W  = COARSE_W + 1;

    typedef struct packed {
        logic              neg;
        logic [CIX_W-1:0]  coarse;
        logic [FINE_W-1:0] fine;
    } fold_t;

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] sin_v;
        logic [MAG_W-1:0] cos_v;
        logic [FK_W-1:0]  fk;
    } look_t;

    typedef struct packed {
        logic              neg;
        logic [MAG_W-1:0]  sin_v;
        logic [PROD_W-1:0] prod;
    } mult_t;

    logic [MAG_W-1:0] tab [NTAB];

    generate
        for (genvar g = 0; g < NTAB; g++) begin : g_tab
            assign tab[g] = MAG_W'(quarter_sine(g, COARSE_W, AMP));
        end
    endgenerate

    // quadrant fold: mirrored index runs 0 .. 2^QTR_W inclusive
    quad_e          quad;
    logic [QTR_W:0] idx;
    fold_t          fold;

    always_comb begin
        quad        = quad_e'(ang_i[ANG_W-1 -: 2]);
        idx         = quad_mirrored(quad)
                    ? ((QTR_W+1)'(1 << QTR_W) - {1'b0, ang_i[QTR_W-1:0]})
                    : {1'b0, ang_i[QTR_W-1:0]};
        fold.neg    = quad_negative(quad);
        fold.coarse = idx[QTR_W -: CIX_W];
        fold.fine   = idx[FINE_W-1:0];
    end

    look_t look_q;
    mult_t mult_q;
    logic  look_vld_q, mult_vld_q;

    // stage 3: table lookup and fine angle in radians
    always_ff @(posedge clk) begin
        if (rst) begin
            look_q     <= '0;
            look_vld_q <= 1'b0;
        end else begin
            look_q.neg   <= fold.neg;
            look_q.sin_v <= tab[fold.coarse];
            look_q.cos_v <= tab[CIX_W'(NTAB - 1) - fold.coarse];
            look_q.fk    <= FK_W'(fold.fine) * FK_W'(FK);
            look_vld_q   <= vld_i;
        end
    end

    // stage 4: the single data multiply, cos(coarse) * fine
    always_ff @(posedge clk) begin
        if (rst) begin
            mult_q     <= '0;
            mult_vld_q <= 1'b0;
        end else begin
            mult_q.neg   <= look_q.neg;
            mult_q.sin_v <= look_q.sin_v;
            mult_q.prod  <= PROD_W'(look_q.cos_v) * PROD_W'(look_q.fk);
            mult_vld_q   <= look_vld_q;
        end
    end

    // stage 5: add correction, clamp, apply sign
    logic [MAG_W:0]   corr, sum;
    logic [MAG_W-1:0] mag;

    always_comb begin
        corr = (MAG_W+1)'((mult_q.prod + PROD_W'(1 << (CORR_SH - 1))) >> CORR_SH);
        sum  = {1'b0, mult_q.sin_v} + corr;
        mag  = (sum > (MAG_W+1)'(AMP)) ? MAG_W'(AMP) : sum[MAG_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_o <= '0;
            vld_o    <= 1'b0;
        end else begin
            sample_o <= mult_q.neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
            vld_o    <= mult_vld_q;
        end
    end
endmodule

// File: rtl/nco_dither_sine.sv
`timescale 1ns/1ps
module nco_dither_sine #(
    parameter int ACC_W     = nco_pkg::ACC_W_DEF,
    parameter int ANG_W     = nco_pkg::ANG_W_DEF,
    parameter int OUT_W     = nco_pkg::OUT_W_DEF,
    parameter int DITH_W    = nco_pkg::DITH_W_DEF,
    parameter int LFSR_W    = nco_pkg::LFSR_W_DEF,
    parameter int COARSE_W  = nco_pkg::COARSE_W_DEF,
    parameter bit DITHER_EN = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic [ACC_W-1:0]        phase_inc,
    output logic signed [OUT_W-1:0] sample_o,
    output logic                    valid_o
);
    logic [ACC_W-1:0] acc_q, inc_q;
    logic [ANG_W-1:0] ang;
    logic             ang_vld;

    nco_phase #(
        .ACC_W(ACC_W), .ANG_W(ANG_W), .DITH_W(DITH_W),
        .LFSR_W(LFSR_W), .DITHER_EN(DITHER_EN)
    ) u_phase (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .phase_inc (phase_inc),
        .acc_o     (acc_q),
        .inc_o     (inc_q),
        .ang_o     (ang),
        .ang_vld_o (ang_vld)
    );

    nco_sine #(
        .ANG_W(ANG_W), .OUT_W(OUT_W), .COARSE_W(COARSE_W)
    ) u_sine (
        .clk      (clk),
        .rst      (rst),
        .ang_i    (ang),
        .vld_i    (ang_vld),
        .sample_o (sample_o),
        .vld_o    (valid_o)
    );
endmodule

// File: rtl/nco_dither_sine_chk.sv
`timescale 1ns/1ps
module nco_dither_sine_chk #(
    parameter int ACC_W = 32,
    parameter int OUT_W = 13,
    parameter int LAT   = nco_pkg::PIPE_LAT
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    en,
    input logic [ACC_W-1:0]        acc,
    input logic [ACC_W-1:0]        inc,
    input logic signed [OUT_W-1:0] sample_o,
    input logic                    valid_o
);
    localparam int AMP = (1 << (OUT_W - 1)) - 1;

    logic [LAT-1:0] en_hist;

    always_ff @(posedge clk) begin
        if (rst) en_hist <= '0;
        else     en_hist <= {en_hist[LAT-2:0], en};
    end

    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (acc == '0 && inc == '0 && !valid_o && sample_o == '0)); // R1

    AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
        en |=> acc == $past(acc) + $past(inc)); // R2

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(acc) && $stable(inc))); // R3

    AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
        valid_o == en_hist[LAT-1]); // R4

    AST_MAG_LIMIT: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (sample_o <= OUT_W'(AMP) && sample_o >= -OUT_W'(AMP))); // R8
endmodule

bind nco_dither_sine nco_dither_sine_chk #(
    .ACC_W(ACC_W), .OUT_W(OUT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .acc      (acc_q),
    .inc      (inc_q),
    .sample_o (sample_o),
    .valid_o  (valid_o)
);

// File: tb/tb_nco_dither_sine.sv
`timescale 1ns/1ps
module tb_nco_dither_sine;
    localparam int LAT = 5;
    localparam int TOL = 14;
    localparam logic [31:0] INC_1M  = 32'd42949673;
    localparam logic [31:0] INC_10M = 32'd429496730;
    localparam logic [31:0] QTR     = 32'h4000_0000;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               en  = 1'b0;
    logic [31:0]        phase_inc = '0;
    logic signed [12:0] sample_o;
    logic               valid_o;

    always #5 clk = ~clk;

    nco_dither_sine dut (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .phase_inc (phase_inc),
        .sample_o  (sample_o),
        .valid_o   (valid_o)
    );

    typedef struct {
        int    exp;
        int    tol;
        int    stamp;
        string req;
    } item_t;

    item_t       sb[$];
    int          total = 0;
    int          bad   = 0;
    int          cyc   = 0;
    logic [31:0] acc_m = '0;
    logic [31:0] inc_m = '0;
    bit          done  = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int ideal(logic [31:0] a);
        real th;
        th = 2.0 * 3.14159265358979 * real'(a) / 4294967296.0;
        return $rtoi($floor(4095.0 * $sin(th) + 0.5));
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // driver: one clock per call, expected item pushed for enabled clocks
    task automatic drive(logic [31:0] inc, bit e, int tol, string req);
        int stamp;
        @(negedge clk);
        phase_inc = inc;
        en        = e;
        stamp     = cyc + 1;
        @(posedge clk);
        if (e) begin
            acc_m = acc_m + inc_m;
            inc_m = inc;
            sb.push_back('{ideal(acc_m), tol, stamp, req});
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(32'hDEAD_BEEF, 1'b0, 0, "R3");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        en  = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(sample_o == 0 && valid_o == 1'b0, "R1", "outputs in reset",
                  int'(sample_o) + (valid_o ? 100000 : 0), 0);
        end
        acc_m = '0;
        inc_m = '0;
        sb.delete();
        rst = 1'b0;
    endtask

    // monitor: pop and compare each emitted sample
    always @(negedge clk) begin
        if (!rst && valid_o) begin
            if (sb.size() == 0) begin
                check(1'b0, "R4", "valid with no pending sample", 1, 0);
            end else begin
                item_t it;
                int    d;
                it = sb.pop_front();
                d  = int'(sample_o) - it.exp;
                if (d < 0) d = -d;
                check(d <= it.tol, it.req, "sample", int'(sample_o), it.exp);
                check(cyc - it.stamp == LAT - 1, "R4", "latency",
                      cyc - it.stamp + 1, LAT);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: outputs cleared while reset is held from time zero
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (i > 0) check(sample_o == 0 && valid_o == 1'b0, "R1", "power-up reset",
                             int'(sample_o) + (valid_o ? 100000 : 0), 0);
        end
        rst = 1'b0;

        // quarter-turn steps: exact points, wrap, first sample at phase 0
        drive(QTR, 1'b1, 0, "R1");      // acc 0
        drive(QTR, 1'b1, 0, "R7");      // angle 1024
        drive(QTR, 1'b1, 0, "R7");      // angle 2048
        drive(QTR, 1'b1, 0, "R7");      // angle 3072
        drive(QTR, 1'b1, 0, "R2");      // wrap to 0
        drive(QTR, 1'b1, 0, "R2");      // angle 1024
        // R3: disabled clocks with a different increment on the pins
        idle(3);
        drive(QTR, 1'b1, 0, "R3");      // continues at angle 2048
        drive(QTR, 1'b1, 0, "R3");      // angle 3072
        idle(8);

        // R8: clamp at angle 1023
        do_reset();
        drive(32'h3FF0_0000, 1'b1, 0, "R1");
        drive(32'h3FF0_0000, 1'b1, 0, "R8");
        drive(32'h3FF0_0000, 1'b1, TOL, "R5 R6");
        idle(8);

        // R8: clamp at angle 3071
        do_reset();
        drive(32'hBFF0_0000, 1'b1, 0, "R1");
        drive(32'hBFF0_0000, 1'b1, 0, "R8");
        drive(32'hBFF0_0000, 1'b1, TOL, "R5 R6");
        idle(8);

        // R9: sustained tones
        for (int i = 0; i < 250; i++) drive(INC_1M, 1'b1, TOL, "R5 R6 R9");
        for (int i = 0; i < 100; i++) drive(INC_10M, 1'b1, TOL, "R6 R9");
        // R2: wrap-heavy increments, one change mid-stream
        for (int i = 0; i < 50; i++) drive(32'hFFFF_FFFF, 1'b1, TOL, "R2 R6");
        for (int i = 0; i < 50; i++) drive(32'h7FFF_FFFF, 1'b1, TOL, "R2 R6");
        for (int i = 0; i < 40; i++) drive(32'h1234_5679, 1'b1, TOL, "R2 R5");
        // R3/R4: enable pattern with gaps; ignored increment while disabled
        for (int i = 0; i < 90; i++) begin
            if ((i % 3) != 0) drive(INC_10M, 1'b1, TOL, "R3 R4 R6");
            else              drive(32'h1357_2468, 1'b0, 0, "R3");
        end
        idle(10);
        check(sb.size() == 0, "R4", "samples still pending", sb.size(), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule